// File: doc/BRIEF.md
# Multi-region image histogram engine

This block gathers intensity histograms from a raster pixel stream for camera statistics. Every accepted pixel is multiplied by a white-balance gain chosen by its place in the colour pattern. The result is clamped to the input range and shifted down to a bin index. The pixel is then counted in every rectangular window that contains it. Each window has its own bank of bin counters. The banks sit one after another in a flat on-chip counter store, so the bin count can be traded against the number of windows: one window with 256 bins, two with 128 each, or three or four with 64 each.

A host programs the block through a small word-addressed register interface. The host sets the enable bit, and the engine arms on the next frame-start pixel. Busy stays high while the frame is counted. After the last pixel of the frame, busy drops and a one-cycle done pulse follows. To read out, the host writes a bin address and then reads the data register repeatedly. The address steps by one after every read. While the clear bit is set, each read also zeroes the word it returned, which is how the store is emptied before the next frame.

Top module: `hist_engine`

## Requirements
- R1: After reset, busy and done are low, the control register (offset 0) reads zero, the read pointer (offset 2) reads zero and every bin counter reads zero.
- R2: Busy rises in the cycle after a valid frame-start pixel that arrives while the enable bit (control bit 0) is set. That pixel and the rest of its frame are counted. A frame that starts while enable is clear counts nothing, and busy stays low.
- R3: The last pixel of a frame is marked by the frame-end input with valid. Two cycles after it is accepted, busy is low, done is high for exactly one cycle, and every count from that frame is in the store.
- R4: The bin-count field (control bits 5:4, code 0/1/2/3 = 32/64/128/256 bins) sets the bin index. The index is the scaled pixel shifted right by PIX_W minus log2 of the bin count.
- R5: In Bayer mode (control bit 3 = 0), gain byte k of the gain register (offset 1, bits 8k+7:8k) applies where k = 2*(row bit 0) + (column bit 0). The scaled value is pixel*gain/32, with 32 meaning unity. Results above 2^PIX_W-1 clamp to the top bin.
- R6: In three-layer mode (control bit 3 = 1), gain byte (column mod 3) applies and the fourth gain byte has no effect.
- R7: Window r holds a horizontal span at offset 4+2r and a vertical span at offset 5+2r, each with the start in bits 15:0 and the end in bits 31:16. A pixel counts in the window when its column lies from start to end inclusive and its row does too. A pixel inside several windows counts in each of them.
- R8: The window-count field (control bits 7:6) holds the number of windows minus one. Windows at or above that count never count, whatever their spans hold.
- R9: The bank of window r starts at bin address r times the bin count.
- R10: A write to offset 2 sets the read pointer. Each read of offset 3 returns the counter at the pointer and then steps the pointer by one.
- R11: While the clear bit (control bit 2) is set, each read of offset 3 also zeroes the counter it returned. With the bit clear, reads leave the counters unchanged.
- R12: A bin counter that holds all ones stays at all ones when more pixels hit it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| pix_valid | input | 1 | Pixel qualifier |
| pix_sof | input | 1 | First pixel of a frame |
| pix_sol | input | 1 | First pixel of a line |
| pix_eof | input | 1 | Last pixel of a frame |
| pix_data | input | PIX_W | Pixel intensity |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe (side effects only on offset 3) |
| reg_addr | input | 4 | Register word offset |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data, combinational from reg_addr |
| busy | output | 1 | Frame being counted |
| done_irq | output | 1 | One-cycle pulse when a frame's counts are complete |

## Verification
The bench sets windows that overlap and a one-pixel window in the frame corner. A design with exclusive end bounds would miss the corner pixel, and one that stopped at the first matching window would undercount the overlap. A fourth window with real spans is left beyond the configured count, so a design that ignores the count field would fill bank three. Gains above unity push bright pixels past the input range: a missing clamp would wrap them into low bins. In three-layer mode a large fourth gain is programmed, which a wrong gain selection would expose. A 320-pixel flat frame on an 8-bit counter shows a counter that wraps instead of holding. A second readout after a clearing pass shows whether clear-on-read really zeroed the store. A pointer write into the middle of a bank checks the stepping readout.

// File: rtl/hist_pkg.sv
package hist_pkg;

    localparam int GAIN_FRAC    = 5;
    localparam int MIN_BINS_LOG = 5;

    localparam logic [3:0] REG_CTRL = 4'd0;
    localparam logic [3:0] REG_GAIN = 4'd1;
    localparam logic [3:0] REG_PTR  = 4'd2;
    localparam logic [3:0] REG_DATA = 4'd3;
    localparam logic [3:0] REG_WIN0 = 4'd4;

    typedef enum logic {
        PAT_BAYER  = 1'b0,
        PAT_LAYER3 = 1'b1
    } pattern_e;

    typedef struct packed {
        logic [15:0] hi;
        logic [15:0] lo;
    } span_t;

    typedef struct packed {
        logic [1:0] nreg_m1;
        logic [1:0] bins_sel;
        pattern_e   pattern;
        logic       clear;
        logic       busy;
        logic       enable;
    } ctrl_t;

    function automatic logic [15:0] scale_pix(input logic [15:0] pix,
                                              input logic [7:0]  g,
                                              input int unsigned pw);
        logic [23:0] prod;
        logic [23:0] top;
        top  = 24'((1 << pw) - 1);
        prod = (24'(pix) * 24'(g)) >> GAIN_FRAC;
        if (prod > top)
            prod = top;
        return prod[15:0];
    endfunction

    function automatic logic [15:0] bin_of(input logic [15:0] v,
                                           input logic [1:0]  sel,
                                           input int unsigned pw);
        return v >> (pw - MIN_BINS_LOG - int'(sel));
    endfunction

endpackage

// File: rtl/hist_pixel_path.sv
module hist_pixel_path
    import hist_pkg::*;
#(
    parameter int PIX_W   = 10,
    parameter int COORD_W = 12,
    parameter int NREG    = 4,
    parameter int AW      = 8
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 pix_valid,
    input  logic                 pix_sof,
    input  logic                 pix_sol,
    input  logic                 pix_eof,
    input  logic [PIX_W-1:0]     pix_data,
    input  logic                 enable,
    input  pattern_e             pattern,
    input  logic [1:0]           bins_sel,
    input  logic [1:0]           nreg_m1,
    input  logic [3:0][7:0]      gains,
    input  span_t                win_h [NREG],
    input  span_t                win_v [NREG],
    output logic [NREG-1:0]      hit_o,
    output logic [AW-1:0]        addr_o [NREG],
    output logic                 busy_o,
    output logic                 done_o
);

    logic [COORD_W-1:0] col_q, row_q, cur_col, cur_row;
    logic               busy_q, done_q, eof_q, sof_go, accept;
    logic [1:0]         gidx;
    logic [15:0]        scaled, bin;
    logic [NREG-1:0]    hit_n;
    logic [AW-1:0]      addr_n [NREG];

    always_comb begin
        cur_col = (pix_sof || pix_sol) ? '0 : col_q + 1'b1;
        cur_row = pix_sof ? '0 : (pix_sol ? row_q + 1'b1 : row_q);
        sof_go  = pix_valid && pix_sof && enable;
        accept  = pix_valid && (busy_q || sof_go);
        if (pattern == PAT_BAYER)
            gidx = {cur_row[0], cur_col[0]};
        else
            gidx = 2'(cur_col % 3);
        scaled = scale_pix(16'(pix_data), gains[gidx], PIX_W);
        bin    = bin_of(scaled, bins_sel, PIX_W);
        for (int r = 0; r < NREG; r++) begin
            hit_n[r] = accept && (2'(r) <= nreg_m1)
                    && (16'(cur_col) >= win_h[r].lo) && (16'(cur_col) <= win_h[r].hi)
                    && (16'(cur_row) >= win_v[r].lo) && (16'(cur_row) <= win_v[r].hi);
            addr_n[r] = AW'((16'(r) << (MIN_BINS_LOG + int'(bins_sel))) | bin);
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            col_q  <= '0;
            row_q  <= '0;
            hit_o  <= '0;
            eof_q  <= 1'b0;
            busy_q <= 1'b0;
            done_q <= 1'b0;
            for (int r = 0; r < NREG; r++)
                addr_o[r] <= '0;
        end else begin
            if (pix_valid) begin
                col_q <= cur_col;
                row_q <= cur_row;
            end
            hit_o  <= hit_n;
            for (int r = 0; r < NREG; r++)
                addr_o[r] <= addr_n[r];
            eof_q  <= accept && pix_eof;
            done_q <= eof_q;
            if (sof_go)
                busy_q <= 1'b1;
            else if (eof_q)
                busy_q <= 1'b0;
        end
    end

    assign busy_o = busy_q;
    assign done_o = done_q;

    AST_BUSY_FALL_DONE: assert property (@(posedge clk) disable iff (rst)
        $fell(busy_o) |-> done_o);  // R3

    AST_IDLE_NO_HIT: assert property (@(posedge clk) disable iff (rst)
        !pix_valid |=> (hit_o == '0));  // R2

    for (genvar gr = 0; gr < NREG; gr++) begin : g_chk
        AST_INACTIVE_WIN: assert property (@(posedge clk) disable iff (rst)
            hit_o[gr] |-> ($past(nreg_m1) >= 2'(gr)));  // R8
    end

endmodule

// File: rtl/hist_bin_store.sv
module hist_bin_store #(
    parameter int NREG  = 4,
    parameter int AW    = 8,
    parameter int CNT_W = 32
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [NREG-1:0]  hit_i,
    input  logic [AW-1:0]    addr_i [NREG],
    input  logic             ptr_wr,
    input  logic [AW-1:0]    ptr_wdata,
    input  logic             data_rd,
    input  logic             clr_en,
    output logic [CNT_W-1:0] rd_word,
    output logic [AW-1:0]    ptr_o
);

    localparam int WORDS = 1 << AW;

    logic [CNT_W-1:0] mem [WORDS];
    logic [WORDS-1:0] inc_vec;
    logic [AW-1:0]    ptr_q;

    always_comb begin
        inc_vec = '0;
        for (int r = 0; r < NREG; r++)
            if (hit_i[r])
                inc_vec[addr_i[r]] = 1'b1;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            ptr_q <= '0;
            for (int w = 0; w < WORDS; w++)
                mem[w] <= '0;
        end else begin
            if (ptr_wr)
                ptr_q <= ptr_wdata;
            else if (data_rd)
                ptr_q <= ptr_q + 1'b1;
            for (int w = 0; w < WORDS; w++) begin
                if (data_rd && clr_en && (ptr_q == AW'(w)))
                    mem[w] <= '0;
                else if (inc_vec[w] && (mem[w] != '1))
                    mem[w] <= mem[w] + 1'b1;
            end
        end
    end

    assign rd_word = mem[ptr_q];
    assign ptr_o   = ptr_q;

    AST_PTR_STEP: assert property (@(posedge clk) disable iff (rst)
        (data_rd && !ptr_wr) |=> (ptr_q == AW'($past(ptr_q) + 1'b1)));  // R10

    AST_CLEAR_ON_READ: assert property (@(posedge clk) disable iff (rst)
        (data_rd && clr_en && !ptr_wr) |=> (mem[$past(ptr_q)] == '0));  // R11

    for (genvar gw = 0; gw < WORDS; gw++) begin : g_sat
        AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (rst)
            ((mem[gw] == '1) && !(data_rd && clr_en && (ptr_q == AW'(gw))))
            |=> (mem[gw] == '1));  // R12
    end

endmodule

// File: rtl/hist_engine.sv
module hist_engine
    import hist_pkg::*;
#(
    parameter int PIX_W    = 10,
    parameter int COORD_W  = 12,
    parameter int NREG     = 4,
    parameter int MAX_BINS = 256,
    parameter int CNT_W    = 32
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             pix_valid,
    input  logic             pix_sof,
    input  logic             pix_sol,
    input  logic             pix_eof,
    input  logic [PIX_W-1:0] pix_data,
    input  logic             reg_wr,
    input  logic             reg_rd,
    input  logic [3:0]       reg_addr,
    input  logic [31:0]      reg_wdata,
    output logic [31:0]      reg_rdata,
    output logic             busy,
    output logic             done_irq
);

    localparam int AW = $clog2(MAX_BINS);

    ctrl_t            ctrl_q;
    logic [3:0][7:0]  gains_q;
    span_t            win_h [NREG];
    span_t            win_v [NREG];
    logic [NREG-1:0]  hit;
    logic [AW-1:0]    addr [NREG];
    logic [CNT_W-1:0] rd_word;
    logic [AW-1:0]    ptr;
    logic             busy_int;

    always_ff @(posedge clk) begin
        if (rst) begin
            ctrl_q  <= '0;
            gains_q <= '0;
            for (int r = 0; r < NREG; r++) begin
                win_h[r] <= '0;
                win_v[r] <= '0;
            end
        end else if (reg_wr) begin
            if (reg_addr == REG_CTRL) begin
                ctrl_q      <= ctrl_t'(reg_wdata[7:0]);
                ctrl_q.busy <= 1'b0;
            end
            if (reg_addr == REG_GAIN)
                gains_q <= reg_wdata;
            for (int r = 0; r < NREG; r++) begin
                if (reg_addr == REG_WIN0 + 4'(2*r))
                    win_h[r] <= reg_wdata;
                if (reg_addr == REG_WIN0 + 4'(2*r + 1))
                    win_v[r] <= reg_wdata;
            end
        end
    end

    always_comb begin
        reg_rdata = '0;
        case (reg_addr)
            REG_CTRL: begin
                reg_rdata[7:0] = ctrl_q;
                reg_rdata[1]   = busy_int;
            end
            REG_GAIN: reg_rdata = gains_q;
            REG_PTR:  reg_rdata = 32'(ptr);
            REG_DATA: reg_rdata = 32'(rd_word);
            default: begin
                for (int r = 0; r < NREG; r++) begin
                    if (reg_addr == REG_WIN0 + 4'(2*r))
                        reg_rdata = win_h[r];
                    if (reg_addr == REG_WIN0 + 4'(2*r + 1))
                        reg_rdata = win_v[r];
                end
            end
        endcase
    end

    hist_pixel_path #(
        .PIX_W(PIX_W), .COORD_W(COORD_W), .NREG(NREG), .AW(AW)
    ) u_path (
        .clk(clk), .rst(rst),
        .pix_valid(pix_valid), .pix_sof(pix_sof), .pix_sol(pix_sol),
        .pix_eof(pix_eof), .pix_data(pix_data),
        .enable(ctrl_q.enable), .pattern(ctrl_q.pattern),
        .bins_sel(ctrl_q.bins_sel), .nreg_m1(ctrl_q.nreg_m1),
        .gains(gains_q), .win_h(win_h), .win_v(win_v),
        .hit_o(hit), .addr_o(addr), .busy_o(busy_int), .done_o(done_irq)
    );

    hist_bin_store #(
        .NREG(NREG), .AW(AW), .CNT_W(CNT_W)
    ) u_store (
        .clk(clk), .rst(rst),
        .hit_i(hit), .addr_i(addr),
        .ptr_wr(reg_wr && (reg_addr == REG_PTR)),
        .ptr_wdata(reg_wdata[AW-1:0]),
        .data_rd(reg_rd && (reg_addr == REG_DATA)),
        .clr_en(ctrl_q.clear),
        .rd_word(rd_word), .ptr_o(ptr)
    );

    assign busy = busy_int;

endmodule

// File: tb/sim_hist_engine.sv
module sim_hist_engine;

    localparam int CLK_PERIOD = 10;
    localparam int PW   = 10;
    localparam int CW   = 8;
    localparam int NW   = 256;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        pix_valid = 0, pix_sof = 0, pix_sol = 0, pix_eof = 0;
    logic [PW-1:0] pix_data = '0;
    logic        reg_wr = 0, reg_rd = 0;
    logic [3:0]  reg_addr = '0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic        busy, done_irq;

    int n_chk = 0, n_fail = 0;
    int expv [NW];
    int b_nreg, b_sel, b_mode;
    int b_gain [4];
    int b_hs [4], b_he [4], b_vs [4], b_ve [4];

    always #(CLK_PERIOD/2) clk = ~clk;

    hist_engine #(.PIX_W(PW), .CNT_W(CW)) u0 (
        .clk(clk), .rst(rst), .pix_valid(pix_valid), .pix_sof(pix_sof),
        .pix_sol(pix_sol), .pix_eof(pix_eof), .pix_data(pix_data),
        .reg_wr(reg_wr), .reg_rd(reg_rd), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .busy(busy), .done_irq(done_irq)
    );

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    task automatic reg_write(input logic [3:0] a, input logic [31:0] d);
        @(negedge clk);
        reg_wr = 1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_wr = 0;
    endtask

    task automatic reg_peek(input logic [3:0] a, output logic [31:0] d);
        @(negedge clk);
        reg_addr = a;
        #1 d = reg_rdata;
    endtask

    function automatic logic [31:0] mk_ctrl(int en, int clr, int mode, int sel, int nm1);
        return 32'(en | (clr << 2) | (mode << 3) | (sel << 4) | (nm1 << 6));
    endfunction

    task automatic configure(input int en, input int mode, input int sel, input int nm1);
        b_mode = mode; b_sel = sel; b_nreg = nm1 + 1;
        reg_write(4'd1, {8'(b_gain[3]), 8'(b_gain[2]), 8'(b_gain[1]), 8'(b_gain[0])});
        for (int r = 0; r < 4; r++) begin
            reg_write(4'(4 + 2*r), {16'(b_he[r]), 16'(b_hs[r])});
            reg_write(4'(5 + 2*r), {16'(b_ve[r]), 16'(b_vs[r])});
        end
        reg_write(4'd0, mk_ctrl(en, 0, mode, sel, nm1));
    endtask

    function automatic int pat(int kind, int row, int col);
        case (kind)
            0: return (row * 37 + col * 11) % 1024;
            1: return (row * 64 + col * 29 + 300) % 1024;
            default: return 500;
        endcase
    endfunction

    function automatic void model_pix(int row, int col, int v);
        int gi, s, bin, lb;
        gi = (b_mode == 0) ? (((row & 1) << 1) | (col & 1)) : (col % 3);
        s  = (v * b_gain[gi]) >> 5;
        if (s > 1023) s = 1023;
        lb  = 5 + b_sel;
        bin = s >> (PW - lb);
        for (int r = 0; r < b_nreg; r++)
            if (col >= b_hs[r] && col <= b_he[r] && row >= b_vs[r] && row <= b_ve[r])
                if (expv[(r << lb) | bin] < 255)
                    expv[(r << lb) | bin]++;
    endfunction

    task automatic send_frame(input int w, input int h, input int kind, input bit on);
        for (int r = 0; r < h; r++) begin
            for (int c = 0; c < w; c++) begin
                @(negedge clk);
                if (r == 0 && c == 1)
                    chk(busy == on, "R2 busy during frame", busy, on);
                pix_valid = 1;
                pix_sof = (r == 0 && c == 0);
                pix_sol = (c == 0);
                pix_eof = (r == h - 1 && c == w - 1);
                pix_data = PW'(pat(kind, r, c));
                if (on) model_pix(r, c, pat(kind, r, c));
            end
        end
        @(negedge clk);
        pix_valid = 0; pix_sof = 0; pix_sol = 0; pix_eof = 0;
        chk(busy == on && done_irq == 0, "R3 busy held one cycle after last pixel", busy, on);
        @(negedge clk);
        chk(busy == 0, "R3 busy low", busy, 0);
        chk(done_irq == on, "R3 done pulse", done_irq, on);
        @(negedge clk);
        chk(done_irq == 0, "R3 done single cycle", done_irq, 0);
    endtask

    task automatic dump(input string tag, input bit clr);
        reg_write(4'd0, mk_ctrl(0, clr, b_mode, b_sel, b_nreg - 1));
        reg_write(4'd2, 32'd0);
        reg_addr = 4'd3;
        for (int w = 0; w < NW; w++) begin
            @(negedge clk);
            reg_rd = 1;
            #1 chk(reg_rdata == 32'(expv[w]), tag, int'(reg_rdata), expv[w]);
        end
        @(negedge clk);
        reg_rd = 0;
        if (clr)
            for (int w = 0; w < NW; w++) expv[w] = 0;
    endtask

    task automatic set_win(input int r, input int hs, input int he, input int vs, input int ve);
        b_hs[r] = hs; b_he[r] = he; b_vs[r] = vs; b_ve[r] = ve;
    endtask

    task automatic t_reset;
        logic [31:0] d;
        reg_peek(4'd0, d); chk(d == 0, "R1 ctrl after reset", int'(d), 0);
        reg_peek(4'd2, d); chk(d == 0, "R1 pointer after reset", int'(d), 0);
        chk(busy == 0 && done_irq == 0, "R1 busy/done after reset", busy, 0);
        b_mode = 0; b_sel = 0; b_nreg = 1;
        dump("R1 store zero after reset", 0);
    endtask

    task automatic t_single;
        for (int k = 0; k < 4; k++) b_gain[k] = 32;
        for (int r = 0; r < 4; r++) set_win(r, 0, 0, 0, 0);
        set_win(0, 0, 15, 0, 7);
        configure(1, 0, 3, 0);
        send_frame(16, 8, 0, 1);
        dump("R4 R10 256-bin single window", 1);
        dump("R11 store empty after clearing pass", 0);
    endtask

    task automatic t_multi;
        b_gain[0] = 32; b_gain[1] = 40; b_gain[2] = 24; b_gain[3] = 64;
        set_win(0, 0, 7, 0, 3);
        set_win(1, 4, 11, 2, 7);
        set_win(2, 15, 15, 7, 7);
        set_win(3, 0, 15, 0, 7);
        configure(1, 0, 1, 2);
        send_frame(16, 8, 1, 1);
        dump("R5 R7 R8 R9 overlapping windows, 64 bins", 1);
    endtask

    task automatic t_layer3;
        b_gain[0] = 16; b_gain[1] = 48; b_gain[2] = 32; b_gain[3] = 255;
        set_win(0, 0, 11, 0, 5);
        set_win(1, 6, 17, 2, 7);
        configure(1, 1, 2, 1);
        send_frame(18, 8, 0, 1);
        dump("R6 three-layer gains, 128 bins", 1);
    endtask

    task automatic t_disabled;
        configure(0, 0, 3, 0);
        send_frame(16, 8, 0, 0);
        dump("R2 disabled frame counts nothing", 0);
    endtask

    task automatic t_saturate;
        logic [31:0] d;
        for (int k = 0; k < 4; k++) b_gain[k] = 32;
        set_win(0, 0, 19, 0, 15);
        configure(1, 0, 0, 0);
        send_frame(20, 16, 2, 1);
        chk(expv[15] == 255, "R12 model saturates", expv[15], 255);
        reg_write(4'd0, mk_ctrl(0, 0, 0, 0, 0));
        reg_write(4'd2, 32'd15);
        reg_addr = 4'd3;
        @(negedge clk); reg_rd = 1;
        #1 d = reg_rdata; chk(d == 255, "R12 counter held at all ones", int'(d), 255);
        @(negedge clk);
        #1 d = reg_rdata; chk(d == 0, "R10 pointer stepped to next bin", int'(d), 0);
        @(negedge clk); reg_rd = 0;
        reg_peek(4'd2, d); chk(d == 17, "R10 pointer after two reads", int'(d), 17);
        dump("R12 R11 saturated store readout", 1);
    endtask

    initial begin
        #(CLK_PERIOD * 150000);
        n_chk++; n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        for (int w = 0; w < NW; w++) expv[w] = 0;
        for (int k = 0; k < 4; k++) b_gain[k] = 32;
        for (int r = 0; r < 4; r++) set_win(r, 0, 0, 0, 0);
        repeat (3) @(negedge clk);
        rst = 0;
        t_reset;
        t_single;
        t_multi;
        t_layer3;
        t_disabled;
        t_saturate;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

endmodule